// File: doc/BRIEF.md
# Keyed-Disable Watchdog Timer

This block is a memory-mapped watchdog counter that is armed the moment reset is released. A fixed clock divider makes a counter tick. The counter climbs from a software-chosen reload value up to all ones. When it wraps, it asserts a one-cycle reset-request output and reloads. Software can halt the counter only by writing an ordered pair of 16-bit key values to one key register. A different ordered pair starts it again.

Each accepted key write is held for a fixed synchronisation window. During that window a pending flag is visible in a status register. Key writes that arrive inside the window are dropped, so software polls the flag before it sends the second key. A self-clearing soft-reset command sends the block through a short reset state. That state restores every default and re-arms the watchdog. A reset-done status bit reads 0 for the whole reset state.

There are two state machines. The key machine has three states: `K_IDLE`, `K_STOP_ARMED` (the first stop key has been taken) and `K_START_ARMED` (the first start key has been taken). It moves only when a synchronised key is applied:
- IDLE to STOP_ARMED on 0xAAAA.
- IDLE to START_ARMED on 0xBBBB.
- STOP_ARMED to IDLE on 0x5555, which stops the counter.
- START_ARMED to IDLE on 0x4444, which starts the counter.
- In an armed state, 0xAAAA or 0xBBBB re-arms for that key pair, and any other value returns the machine to IDLE.

The block machine has two states, `BLK_ACTIVE` and `BLK_SRESET`. It goes from ACTIVE to SRESET on a soft-reset command, and returns to ACTIVE after 4 cycles.

Top module: `wdt_keyed_top`

## Requirements
- R1: Register map. Byte offsets: 0x10 is control, where bit 1 is soft reset (write-only; reads 0). 0x14 is system status, where bit 0 is reset-done. 0x28 is the live count (read-only). 0x2C is the reload value (read/write). 0x34 is pending status, where bit 4 is the key write in flight. 0x48 is the key register (write-only; reads 0). Any other offset reads 0.
- R2: After hardware reset the counter runs, reload reads DEFAULT_LOAD, reset-done reads 1 and the pending bit reads 0.
- R3: The counter advances by one every DIV clock cycles while running. When it passes 0xFFFFFFFF it reloads and drives wdt_reset_req high for exactly one cycle.
- R4: A write to offset 0x2C stores the reload value and loads it into the counter at once.
- R5: Once the key 0xAAAA has been applied, applying 0x5555 stops the counter. It then holds its value and requests no reset.
- R6: Once the key 0xBBBB has been applied, applying 0x4444 restarts a stopped counter.
- R7: Any other applied value between the two keys of a pair clears the sequence. A pair written in the wrong order has no effect on the run state.
- R8: An accepted key write sets the pending bit for exactly 3 cycles, and the key takes effect when the bit clears. Key writes made while the bit is set are ignored.
- R9: Writing 1 to control bit 1 while reset-done is 1 drives reset-done to 0 for exactly 4 cycles. During that time the block returns to the post-reset state (running, reload = DEFAULT_LOAD, sequence cleared, not pending).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Byte offset for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| wdt_reset_req | output | 1 | One-cycle reset request when the counter wraps |

## Verification
The bench writes the second stop key while the first is still pending. A design that accepts writes during the window would stop early, when the counter must keep running. It also puts a stray value between keys and writes the restart pair in reverse order. A design that keeps partial sequences would change its run state on those writes. The pending window and the reset-done window are timed cycle by cycle, so an off-by-one in either counter shows up. The bench also checks that a soft reset issued while the counter is stopped brings back a running counter and the default reload; a block that skips re-arming would stay silent.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        K_IDLE,
        K_STOP_ARMED,
        K_START_ARMED
    } key_state_e;

    typedef enum logic {
        BLK_ACTIVE,
        BLK_SRESET
    } blk_state_e;

    localparam logic [7:0] OFS_CTRL  = 8'h10;
    localparam logic [7:0] OFS_STAT  = 8'h14;
    localparam logic [7:0] OFS_COUNT = 8'h28;
    localparam logic [7:0] OFS_LOAD  = 8'h2C;
    localparam logic [7:0] OFS_PEND  = 8'h34;
    localparam logic [7:0] OFS_KEY   = 8'h48;

    localparam int PEND_BIT  = 4;
    localparam int SRST_BIT  = 1;

    localparam logic [15:0] KEY_STOP_A  = 16'hAAAA;
    localparam logic [15:0] KEY_STOP_B  = 16'h5555;
    localparam logic [15:0] KEY_START_A = 16'hBBBB;
    localparam logic [15:0] KEY_START_B = 16'h4444;

endpackage

// File: rtl/wdt_key_seq.sv
module wdt_key_seq
    import wdt_pkg::*;
#(
    parameter int PEND_CYCLES = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        key_wr,
    input  logic [15:0] key_val,
    output logic        pending,
    output logic        stop_pulse,
    output logic        start_pulse
);
    localparam int PW = $clog2(PEND_CYCLES + 1);

    key_state_e  state_q, state_d;
    logic [PW-1:0] pcnt_q;
    logic [15:0]   held_q;
    logic          accept, apply;

    assign accept  = key_wr && (pcnt_q == '0) && !clr;
    assign apply   = (pcnt_q == PW'(1)) && !clr;
    assign pending = (pcnt_q != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt_q <= '0;
            held_q <= '0;
        end else if (clr) begin
            pcnt_q <= '0;
            held_q <= '0;
        end else if (accept) begin
            pcnt_q <= PW'(PEND_CYCLES);
            held_q <= key_val;
        end else if (pcnt_q != '0) begin
            pcnt_q <= pcnt_q - PW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   state_q <= K_IDLE;
        else if (clr) state_q <= K_IDLE;
        else          state_q <= state_d;
    end

    always_comb begin
        state_d     = state_q;
        stop_pulse  = 1'b0;
        start_pulse = 1'b0;
        if (apply) begin
            unique case (state_q)
                K_IDLE: begin
                    if (held_q == KEY_STOP_A)       state_d = K_STOP_ARMED;
                    else if (held_q == KEY_START_A) state_d = K_START_ARMED;
                end
                K_STOP_ARMED: begin
                    if (held_q == KEY_STOP_B) begin
                        stop_pulse = 1'b1;
                        state_d    = K_IDLE;
                    end else if (held_q == KEY_STOP_A)  state_d = K_STOP_ARMED;
                    else if (held_q == KEY_START_A)     state_d = K_START_ARMED;
                    else                                state_d = K_IDLE;
                end
                K_START_ARMED: begin
                    if (held_q == KEY_START_B) begin
                        start_pulse = 1'b1;
                        state_d     = K_IDLE;
                    end else if (held_q == KEY_STOP_A)  state_d = K_STOP_ARMED;
                    else if (held_q == KEY_START_A)     state_d = K_START_ARMED;
                    else                                state_d = K_IDLE;
                end
                default: state_d = K_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int          CW           = 32,
    parameter int          DIV          = 4,
    parameter logic [31:0] DEFAULT_LOAD = 32'hFFFF_0000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          stop,
    input  logic          start,
    input  logic          load_wr,
    input  logic [CW-1:0] load_val,
    output logic [CW-1:0] count,
    output logic [CW-1:0] load_q,
    output logic          running,
    output logic          expire
);
    localparam int            DW   = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] TOP  = '1;
    localparam logic [CW-1:0] DEFL = DEFAULT_LOAD[CW-1:0];

    logic [DW-1:0] pre_q;
    logic          tick;

    assign tick = (pre_q == DW'(DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q   <= '0;
            count   <= DEFL;
            load_q  <= DEFL;
            running <= 1'b1;
            expire  <= 1'b0;
        end else if (clr) begin
            pre_q   <= '0;
            count   <= DEFL;
            load_q  <= DEFL;
            running <= 1'b1;
            expire  <= 1'b0;
        end else begin
            expire <= 1'b0;
            if (stop)       running <= 1'b0;
            else if (start) running <= 1'b1;
            if (load_wr) begin
                load_q <= load_val;
                count  <= load_val;
                pre_q  <= '0;
            end else if (running) begin
                pre_q <= tick ? '0 : pre_q + DW'(1);
                if (tick) begin
                    if (count == TOP) begin
                        count  <= load_q;
                        expire <= 1'b1;
                    end else begin
                        count <= count + CW'(1);
                    end
                end
            end
        end
    end
endmodule

// File: rtl/wdt_softrst.sv
module wdt_softrst
    import wdt_pkg::*;
#(
    parameter int BUSY_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic srst_req,
    output logic busy,
    output logic done
);
    localparam int BW = $clog2(BUSY_CYCLES + 1);

    blk_state_e   state_q, state_d;
    logic [BW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BLK_ACTIVE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == BLK_ACTIVE && srst_req) cnt_q <= BW'(BUSY_CYCLES);
            else if (cnt_q != '0)                  cnt_q <= cnt_q - BW'(1);
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BLK_ACTIVE: if (srst_req)          state_d = BLK_SRESET;
            BLK_SRESET: if (cnt_q == BW'(1))   state_d = BLK_ACTIVE;
            default:                           state_d = BLK_ACTIVE;
        endcase
    end

    always_comb begin
        busy = (state_q == BLK_SRESET);
        done = (state_q == BLK_ACTIVE);
    end
endmodule

// File: rtl/wdt_keyed_top.sv
module wdt_keyed_top
    import wdt_pkg::*;
#(
    parameter int          DIV          = 4,
    parameter int          PEND_CYCLES  = 3,
    parameter int          BUSY_CYCLES  = 4,
    parameter logic [31:0] DEFAULT_LOAD = 32'hFFFF_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        wdt_reset_req
);
    logic        key_pend, stop_p, start_p;
    logic        busy, done, running;
    logic [31:0] count, load_q;
    logic        wr_key, wr_load, srst_req;

    assign wr_key   = bus_wr && (bus_addr == OFS_KEY);
    assign wr_load  = bus_wr && (bus_addr == OFS_LOAD) && !busy;
    assign srst_req = bus_wr && (bus_addr == OFS_CTRL) && bus_wdata[SRST_BIT];

    wdt_softrst #(.BUSY_CYCLES(BUSY_CYCLES)) u_srst (
        .clk(clk), .rst_n(rst_n), .srst_req(srst_req), .busy(busy), .done(done)
    );

    wdt_key_seq #(.PEND_CYCLES(PEND_CYCLES)) u_keys (
        .clk(clk), .rst_n(rst_n), .clr(busy), .key_wr(wr_key),
        .key_val(bus_wdata[15:0]), .pending(key_pend),
        .stop_pulse(stop_p), .start_pulse(start_p)
    );

    wdt_counter #(.CW(32), .DIV(DIV), .DEFAULT_LOAD(DEFAULT_LOAD)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(busy), .stop(stop_p), .start(start_p),
        .load_wr(wr_load), .load_val(bus_wdata), .count(count), .load_q(load_q),
        .running(running), .expire(wdt_reset_req)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFS_STAT:  bus_rdata[0] = done;
            OFS_COUNT: bus_rdata = count;
            OFS_LOAD:  bus_rdata = load_q;
            OFS_PEND:  bus_rdata[PEND_BIT] = key_pend;
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker
    import wdt_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        bus_wr,
    input logic [7:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic        wdt_reset_req,
    input logic        key_pend,
    input logic        done,
    input logic        busy,
    input logic        running,
    input logic [31:0] count
);
    p_pulse_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_reset_req |=> !wdt_reset_req);

    p_pend_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(key_pend) |=> key_pend);

    p_stopped_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !busy && !(bus_wr && bus_addr == OFS_LOAD)) |=> $stable(count));

    p_srst_enter_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && bus_wr && bus_addr == OFS_CTRL && bus_wdata[SRST_BIT]) |=> !done);

    p_rearm_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (running && !key_pend));
endmodule

bind wdt_keyed_top wdt_checker u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .wdt_reset_req(wdt_reset_req), .key_pend(key_pend),
    .done(done), .busy(busy), .running(running), .count(count)
);

// File: tb/tb_wdt_keyed_top.sv
module tb_wdt_keyed_top;
    localparam logic [31:0] DEFL = 32'hFFFF_0000;

    logic        clk = 0, rst_n = 0, bus_wr = 0;
    logic [7:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0, bus_rdata;
    logic        wdt_reset_req;
    int checks = 0, fails = 0, pulses = 0;

    always #4 clk = ~clk;

    wdt_keyed_top #(.DEFAULT_LOAD(DEFL)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wdt_reset_req(wdt_reset_req)
    );

    always @(negedge clk) if (rst_n && wdt_reset_req) pulses++;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        bus_addr = a; #1; v = bus_rdata;
    endtask

    task automatic wait_pend();
        logic [31:0] v;
        for (int i = 0; i < 10; i++) begin
            rd(8'h34, v);
            if (v[4] == 1'b0) break;
            @(negedge clk);
        end
    endtask

    task automatic is_running(output bit r);
        logic [31:0] a, b;
        rd(8'h28, a);
        repeat (12) @(negedge clk);
        rd(8'h28, b);
        r = (a != b);
    endtask

    // Bench reference of the key sequence rules (R5, R6, R7)
    function automatic void model_key(inout int st, inout bit run, input logic [15:0] k);
        int nx;
        nx = 0;
        if (st == 1 && k == 16'h5555) begin run = 0; nx = 0; end
        else if (st == 2 && k == 16'h4444) begin run = 1; nx = 0; end
        else if (k == 16'hAAAA) nx = 1;
        else if (k == 16'hBBBB) nx = 2;
        st = nx;
    endfunction

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
    end

    initial begin
        logic [31:0] v;
        bit r;
        int st;
        bit mrun;
        int p0;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R2 / R1 reset state and map
        rd(8'h14, v); chk("R2 done", v, 32'h1);
        rd(8'h34, v); chk("R2 pend", v, 32'h0);
        rd(8'h2C, v); chk("R2 load", v, DEFL);
        rd(8'h48, v); chk("R1 key reads 0", v, 32'h0);
        rd(8'h10, v); chk("R1 ctrl reads 0", v, 32'h0);
        is_running(r); chk("R2 running from reset", 32'(r), 32'h1);

        // R4 load then R3 expiry
        wr(8'h2C, 32'hFFFF_FFF8);
        rd(8'h2C, v); chk("R4 load stored", v, 32'hFFFF_FFF8);
        rd(8'h28, v); chk("R4 counter loaded", v, 32'hFFFF_FFF8);
        p0 = pulses;
        repeat (50) @(negedge clk);
        chk("R3 one reset request", 32'(pulses - p0), 32'h1);
        rd(8'h28, v); chk("R3 reloaded", 32'(v >= 32'hFFFF_FFF8), 32'h1);

        // R8 second key during pending is dropped
        wr(8'h48, 32'hAAAA);
        wr(8'h48, 32'h5555);
        wait_pend();
        is_running(r); chk("R8 key during pending ignored", 32'(r), 32'h1);
        wr(8'h48, 32'h5555);
        wait_pend();
        is_running(r); chk("R5 stopped", 32'(r), 32'h0);
        wr(8'h2C, 32'hFFFF_FFF8);
        p0 = pulses;
        repeat (60) @(negedge clk);
        chk("R5 no request when stopped", 32'(pulses - p0), 32'h0);

        // R7 wrong-order restart
        wr(8'h48, 32'h4444); wait_pend();
        wr(8'h48, 32'hBBBB); wait_pend();
        wr(8'h48, 32'h1234); wait_pend();
        is_running(r); chk("R7 wrong order no restart", 32'(r), 32'h0);

        // R8 pending window length, then R6 restart
        wr(8'h48, 32'hBBBB);
        rd(8'h34, v); chk("R8 pend cycle1", v, 32'h10);
        @(negedge clk); rd(8'h34, v); chk("R8 pend cycle2", v, 32'h10);
        @(negedge clk); rd(8'h34, v); chk("R8 pend cycle3", v, 32'h10);
        @(negedge clk); rd(8'h34, v); chk("R8 pend clears", v, 32'h0);
        wr(8'h48, 32'h4444); wait_pend();
        is_running(r); chk("R6 restarted", 32'(r), 32'h1);

        // R7 stray value between stop keys
        wr(8'h48, 32'hAAAA); wait_pend();
        wr(8'h48, 32'h0001); wait_pend();
        wr(8'h48, 32'h5555); wait_pend();
        is_running(r); chk("R7 interrupted stop", 32'(r), 32'h1);

        // R9 soft reset from the stopped state
        wr(8'h48, 32'hAAAA); wait_pend();
        wr(8'h48, 32'h5555); wait_pend();
        wr(8'h2C, 32'h0000_0100);
        wr(8'h48, 32'hAAAA);
        wr(8'h10, 32'h2);
        for (int i = 0; i < 4; i++) begin
            rd(8'h14, v); chk("R9 done low", v, 32'h0);
            @(negedge clk);
        end
        rd(8'h14, v); chk("R9 done returns", v, 32'h1);
        rd(8'h10, v); chk("R9 ctrl self-clears", v, 32'h0);
        rd(8'h2C, v); chk("R9 load default", v, DEFL);
        rd(8'h34, v); chk("R9 pend cleared", v, 32'h0);
        is_running(r); chk("R9 re-armed", 32'(r), 32'h1);

        // R5 R6 R7 R8 random key traffic against the bench model
        st = 0; mrun = 1;
        for (int n = 0; n < 60; n++) begin
            int sel;
            logic [15:0] k;
            sel = int'($urandom % 6);
            case (sel)
                0: k = 16'hAAAA;
                1: k = 16'h5555;
                2: k = 16'hBBBB;
                3: k = 16'h4444;
                default: k = 16'($urandom);
            endcase
            wr(8'h48, {16'h0, k});
            model_key(st, mrun, k);
            if ($urandom % 4 == 0) wr(8'h48, 32'h5555);
            wait_pend();
            if (n % 3 == 2) begin
                is_running(r);
                chk("R7 random sequence run state", 32'(r), 32'(mrun));
            end
        end

        summary();
    end
endmodule